// File: doc/BRIEF.md
# Three-Region Word Bus Decoder

This block sits behind a single word-wide bus and spreads a 16-bit word address across three storage targets: a main working memory, a frame buffer for a display, and a single input-device register. The bus master presents an address, a write value and a load strobe. The block returns a read value in the same cycle. When the strobe is high, it commits the write value to the one selected target at the next clock edge.

The map is asymmetric. The top address bit separates main memory from the peripheral half. Inside the peripheral half, address bit 13 separates the frame buffer from the input register. The regions therefore have different sizes, and the peripheral half is mirrored across bit 14. All storage uses clocked-write, combinational-read behaviour. A read always shows what was stored before the coming edge.

The storage arrays are modelled inside the block. Their depths are parameters, so that a full-size build or a small test build can be chosen.

Top module: `mmap_bus_decoder`

## Requirements
- R1: With address bit 15 at 0, the access targets main memory at word index `addr[MAIN_AW-1:0]`. MAIN_AW is at most 15 and defaults to 8. Index bits above MAIN_AW alias to the same word.
- R2: With address bit 15 at 1 and bit 13 at 1, the access targets the single input register, whatever the other address bits are.
- R3: With address bit 15 at 1 and bit 13 at 0, the access targets the frame buffer at word index `addr[SCR_AW-1:0]`. SCR_AW is at most 13 and defaults to 6.
- R4: During a cycle with load high, `rdata` shows the contents from before the write. The written value becomes readable only after the clock edge.
- R5: If `wdata` changes several times within one cycle while load is high, the value present at the clock edge is the one stored.
- R6: With load low, no target changes across a clock edge.
- R7: When bit 15 is 1, address bit 14 has no effect. An address with bit 14 set reaches the same word as the same address with bit 14 clear.
- R8: A write raises the write enable of the decoded target only. Words in the other two regions keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| load | input | 1 | Write strobe for the addressed word |
| addr | input | 16 | Word address across all three regions |
| wdata | input | DW | Value to store when load is high |
| rdata | output | DW | Current contents of the addressed word |

## Verification
Several behaviours are checked by the assertions on every cycle:
- at most one write enable is raised, and it matches the decoded region;
- the input register holds its value when it is not enabled, and takes the bus value after an enabled edge;
- a read in the input-register region returns that register.

Other behaviours can only be shown by the bench's scenarios:
- the contents of the two arrays, including aliasing and mirroring;
- the old-value read during a pending write;
- last-value-wins within a cycle;
- that a write into one region leaves equal indices in the other region untouched.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int ADDR_W = 16;
  localparam int BIT_PERIPH = 15;
  localparam int BIT_INPUT  = 13;

  typedef enum logic [1:0] {
    RGN_MAIN   = 2'd0,
    RGN_SCREEN = 2'd1,
    RGN_INPUT  = 2'd2
  } region_t;

  // Region choice from the two decode bits; bit 14 plays no part.
  function automatic region_t region_of(input logic [ADDR_W-1:0] a);
    if (!a[BIT_PERIPH])     return RGN_MAIN;
    else if (a[BIT_INPUT])  return RGN_INPUT;
    else                    return RGN_SCREEN;
  endfunction
endpackage

// File: rtl/mmap_decode.sv
module mmap_decode
  import mmap_pkg::*;
#(
  parameter int MAIN_AW = 8,
  parameter int SCR_AW  = 6
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               load,
  output region_t            region,
  output logic               we_main,
  output logic               we_screen,
  output logic               we_input,
  output logic [MAIN_AW-1:0] main_idx,
  output logic [SCR_AW-1:0]  scr_idx
);
  logic unused_addr_bits;

  assign region    = region_of(addr);
  assign we_main   = load && (region == RGN_MAIN);
  assign we_screen = load && (region == RGN_SCREEN);
  assign we_input  = load && (region == RGN_INPUT);
  assign main_idx  = addr[MAIN_AW-1:0];
  assign scr_idx   = addr[SCR_AW-1:0];
  assign unused_addr_bits = ^addr;
endmodule

// File: rtl/mmap_wordmem.sv
module mmap_wordmem #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wd;
  end

  assign rd = cells[idx];
endmodule

// File: rtl/mmap_wordreg.sv
module mmap_wordreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (we) q <= d;
  end
endmodule

// File: rtl/mmap_bus_decoder.sv
module mmap_bus_decoder
  import mmap_pkg::*;
#(
  parameter int DW      = 16,
  parameter int MAIN_AW = 8,
  parameter int SCR_AW  = 6
) (
  input  logic              clk,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  region_t            region;
  logic               we_main, we_screen, we_input;
  logic [MAIN_AW-1:0] main_idx;
  logic [SCR_AW-1:0]  scr_idx;
  logic [DW-1:0]      main_rd, scr_rd, input_q;

  mmap_decode #(.MAIN_AW(MAIN_AW), .SCR_AW(SCR_AW)) u_decode (
    .addr(addr), .load(load), .region(region),
    .we_main(we_main), .we_screen(we_screen), .we_input(we_input),
    .main_idx(main_idx), .scr_idx(scr_idx)
  );

  mmap_wordmem #(.DW(DW), .AW(MAIN_AW)) u_main (
    .clk(clk), .we(we_main), .idx(main_idx), .wd(wdata), .rd(main_rd)
  );

  mmap_wordmem #(.DW(DW), .AW(SCR_AW)) u_screen (
    .clk(clk), .we(we_screen), .idx(scr_idx), .wd(wdata), .rd(scr_rd)
  );

  mmap_wordreg #(.DW(DW)) u_input (
    .clk(clk), .we(we_input), .d(wdata), .q(input_q)
  );

  always_comb begin
    case (region)
      RGN_MAIN:   rdata = main_rd;
      RGN_SCREEN: rdata = scr_rd;
      RGN_INPUT:  rdata = input_q;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/mmap_bus_decoder_chk.sv
module mmap_bus_decoder_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          load,
  input logic [15:0]   addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          we_main,
  input logic          we_screen,
  input logic          we_input,
  input logic [DW-1:0] input_q
);
  logic primed = 1'b0;
  always @(posedge clk) primed <= 1'b1;

  // R8
  we_single_chk: assert property (@(posedge clk) disable iff (!primed)
    $countones({we_main, we_screen, we_input}) <= 1);

  // R1
  main_sel_chk: assert property (@(posedge clk) disable iff (!primed)
    (load && !addr[15]) |-> (we_main && !we_screen && !we_input));

  // R2
  input_sel_chk: assert property (@(posedge clk) disable iff (!primed)
    (load && addr[15] && addr[13]) |-> (we_input && !we_main && !we_screen));

  // R3
  screen_sel_chk: assert property (@(posedge clk) disable iff (!primed)
    (load && addr[15] && !addr[13]) |-> (we_screen && !we_main && !we_input));

  // R6
  idle_no_we_chk: assert property (@(posedge clk) disable iff (!primed)
    !load |-> !(we_main || we_screen || we_input));

  // R8
  input_hold_chk: assert property (@(posedge clk) disable iff (!primed)
    !we_input |=> (input_q == $past(input_q)));

  // R5
  input_commit_chk: assert property (@(posedge clk) disable iff (!primed)
    we_input |=> (input_q == $past(wdata)));

  // R2
  input_read_chk: assert property (@(posedge clk) disable iff (!primed)
    (addr[15] && addr[13]) |-> (rdata == input_q));
endmodule

bind mmap_bus_decoder mmap_bus_decoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .load(load), .addr(addr), .wdata(wdata), .rdata(rdata),
  .we_main(we_main), .we_screen(we_screen), .we_input(we_input),
  .input_q(input_q)
);

// File: tb/mmap_bus_decoder_bench.sv
module mmap_bus_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        load = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmap_bus_decoder u_mmap_bus_decoder (
    .clk(clk), .load(load), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // {address, data}
  localparam logic [31:0] WR_VEC [9] = '{
    {16'h0000, 16'h1111},   // R1 main[0]
    {16'h00FF, 16'h2222},   // R1 main[255]
    {16'h8000, 16'h3333},   // R3 screen[0]
    {16'h803F, 16'h4444},   // R3 screen[63]
    {16'hA000, 16'h5555},   // R2 input
    {16'h0010, 16'h6666},   // R1 main[16]
    {16'hC001, 16'h7777},   // R7 screen[1] via mirror
    {16'hFFFF, 16'h8888},   // R2 input, other bits set
    {16'h8002, 16'h9999}    // R3 screen[2]
  };

  // {address, expected}
  localparam logic [31:0] RD_VEC [12] = '{
    {16'h0000, 16'h1111},   // R8 main[0] untouched by screen[0]
    {16'h00FF, 16'h2222},
    {16'h8000, 16'h3333},   // R8 screen[0] untouched by main/input
    {16'hC000, 16'h3333},   // R7 mirror
    {16'h803F, 16'h4444},
    {16'hE123, 16'h8888},   // R2 any other bits
    {16'hA000, 16'h8888},
    {16'h0010, 16'h6666},
    {16'h8001, 16'h7777},   // R7 written through mirror
    {16'h8002, 16'h9999},
    {16'h7F00, 16'h1111},   // R1 alias above MAIN_AW
    {16'h8040, 16'h3333}    // R3 alias above SCR_AW
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; load = 1'b1;
    @(posedge clk);
    #1 load = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [15:0] a, input logic [15:0] exp);
    @(negedge clk);
    addr = a; load = 1'b0;
    #1 check(req, rdata, exp);
  endtask

  initial begin
    logic [15:0] first;
    // Power-up: idle load keeps input register steady
    @(negedge clk);
    addr = 16'hA000;
    #1 first = rdata;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check("R6 power-up hold", rdata, first);

    for (int i = 0; i < 9; i++) wr(WR_VEC[i][31:16], WR_VEC[i][15:0]);
    for (int i = 0; i < 12; i++) rd_check("R1/R2/R3/R7/R8 table", RD_VEC[i][31:16], RD_VEC[i][15:0]);

    // R4 old value shown during pending write
    wr(16'h0005, 16'h1234);
    @(negedge clk);
    addr = 16'h0005; wdata = 16'hAAAA; load = 1'b1;
    #1 check("R4 pre-edge", rdata, 16'h1234);
    @(posedge clk);
    #1 load = 1'b0;
    #1 check("R4 post-edge", rdata, 16'hAAAA);

    // R5 last value before the edge wins
    @(negedge clk);
    addr = 16'h0005; load = 1'b1; wdata = 16'hBBBB;
    #1 wdata = 16'hCCCC;
    #1 check("R5 still old", rdata, 16'hAAAA);
    @(posedge clk);
    #1 load = 1'b0;
    rd_check("R5 last value", 16'h0005, 16'hCCCC);

    // R5 on the input register
    @(negedge clk);
    addr = 16'hB000; load = 1'b1; wdata = 16'h0F0F;
    #1 wdata = 16'hF0F0;
    @(posedge clk);
    #1 load = 1'b0;
    rd_check("R5 input last value", 16'hA000, 16'hF0F0);

    // R6 load low leaves contents
    @(negedge clk);
    addr = 16'h0005; wdata = 16'hDEAD; load = 1'b0;
    repeat (3) @(posedge clk);
    rd_check("R6 main hold", 16'h0005, 16'hCCCC);
    @(negedge clk);
    addr = 16'hA000; wdata = 16'hDEAD;
    repeat (2) @(posedge clk);
    rd_check("R6 input hold", 16'hA000, 16'hF0F0);

    // R8 input write leaves screen[0] and main[0]
    wr(16'hA000, 16'h0001);
    rd_check("R8 screen after input write", 16'h8000, 16'h3333);
    rd_check("R8 main after input write", 16'h0000, 16'h1111);
    rd_check("R2 input new", 16'hA000, 16'h0001);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule